// File: doc/BRIEF.md
# Bit-Band Alias Translator

This block sits between one bus master and a word-wide memory or peripheral port. Two address windows act as aliases. Each 32-bit word in an alias window stands for a single bit of a word in the matching underlying region. When a request falls in one of these windows, the block turns it into a bit operation on the target word. An alias read fetches the target word and returns the chosen bit. An alias write reads the target word, replaces the chosen bit and writes the word back. Both downstream beats of an alias write are locked, so no other transfer can come between them. Every other address is forwarded unchanged.

The request channel on each side uses valid/ready. The master holds `up_valid` and its request fields stable until it sees `up_ready`, which the block raises for exactly one cycle. For a read, `up_rdata` is valid in that same cycle. Downstream, the block holds each beat until `dn_ready` accepts it. For a downstream read, the port later returns the word on `dn_rdata` together with a `dn_rvalid` pulse. The block handles one upstream request at a time.

Top module: `bitalias_xlate`

## Requirements
- R1: An address outside both alias windows produces exactly one downstream beat. That beat carries the same address, direction, write data and byte enables as the request. For a read, the returned word is passed upward unchanged.
- R2: Addresses 0x2200_0000..0x23FF_FFFF alias the region at 0x2000_0000, and addresses 0x4200_0000..0x43FF_FFFF alias the region at 0x4000_0000. The byte offset is (addr - alias_base) >> 5 and the bit number is ((addr - alias_base) >> 2) & 7. For example, 0x2200_6008 acts on bit 2 of the byte at 0x2000_0300.
- R3: Byte order is little-endian. Byte offset n selects bit position (n mod 4)*8 + bit_number of the word at region_base + (n & ~3).
- R4: An alias read issues one unlocked downstream read of the target word with all four byte enables set. It returns the selected bit in bit 0 of `up_rdata`, with bits 31..1 zero.
- R5: An alias write issues a read of the target word, then a write to the same word with all byte enables set. The written word equals the word just read, with only the selected bit replaced.
- R6: An alias write takes the new bit value from bit 0 of `up_wdata`. Bits 31..1 of `up_wdata` have no effect.
- R7: `dn_lock` is high on both beats of an alias write and stays high between them. It falls once the write-back has been accepted. It is low on pass-through beats and on alias reads.
- R8: Only one operation is in flight at a time. `up_ready` stays low until the operation has finished downstream; for an alias write, that means the write-back has been accepted. `up_ready` is never high for two cycles in a row.
- R9: Address bits 1..0 of an alias address are ignored. An alias address with these bits set acts on the same bit as the word-aligned alias address.
- R10: While reset is held, and in the first cycle after it, `up_ready`, `dn_valid` and `dn_lock` are low.
- R11: Addresses inside the underlying regions are plain accesses. They pass through with their byte enables, so partial-word writes reach the port untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Master request valid |
| up_ready | output | 1 | One-cycle completion/accept pulse to the master |
| up_write | input | 1 | Request is a write |
| up_addr | input | 32 | Request byte address |
| up_wdata | input | 32 | Request write data |
| up_be | input | 4 | Request byte enables |
| up_rdata | output | 32 | Read data, valid while up_ready is high on a read |
| dn_valid | output | 1 | Downstream beat valid |
| dn_ready | input | 1 | Downstream beat accepted |
| dn_write | output | 1 | Downstream beat is a write |
| dn_addr | output | 32 | Downstream byte address |
| dn_wdata | output | 32 | Downstream write data |
| dn_be | output | 4 | Downstream byte enables |
| dn_lock | output | 1 | Locked sequence in progress |
| dn_rdata | input | 32 | Downstream read data |
| dn_rvalid | input | 1 | Downstream read data valid |

## Verification
The hardest case to reach is a locked read-modify-write while the port refuses beats. The bench must hold the read beat, the wait for data and the write-back under back-pressure, and confirm that `up_ready` never shows up early and that the lock never drops partway through. To get there, the bench repeats alias writes and alias reads while a downstream model withholds `dn_ready` on a fixed cycle pattern. A reference memory, updated by the bench's own alias arithmetic, then checks every merged word and every returned bit. Further cases cover the top word of the SRAM window, lane selection across bytes of one word, and data bits that must not leak into the merge.

// File: rtl/bitalias_pkg.sv
package bitalias_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PASS,
    S_PWAIT,
    S_ARD,
    S_AWAIT,
    S_AWB,
    S_DONE
  } xl_state_t;

  typedef struct packed {
    logic        hit;
    logic [31:0] word;
    logic [4:0]  pos;
  } alias_dec_t;

endpackage

// File: rtl/bitalias_decode.sv
module bitalias_decode #(
  parameter int                 NWIN      = 2,
  parameter logic [1:0][31:0]   BASES     = {32'h4000_0000, 32'h2000_0000},
  parameter logic [31:0]        ALIAS_OFS = 32'h0200_0000,
  parameter int                 REGION_LG = 20
) (
  input  logic [31:0]               addr,
  output bitalias_pkg::alias_dec_t  dec
);
  localparam int ALIAS_LG = REGION_LG + 5;

  logic [NWIN-1:0] hit;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam logic [31:0] WBASE = BASES[w] + ALIAS_OFS;
    assign hit[w] = (addr[31:ALIAS_LG] == WBASE[31:ALIAS_LG]);
  end

  logic [31:0] off_w;
  always_comb begin
    off_w = '0;
    off_w[REGION_LG-1:2] = addr[ALIAS_LG-1:7];
  end

  always_comb begin
    dec      = '0;
    dec.pos  = {addr[6:5], addr[4:2]};
    for (int w = NWIN - 1; w >= 0; w--) begin
      if (hit[w]) begin
        dec.hit  = 1'b1;
        dec.word = BASES[w] | off_w;
      end
    end
  end
endmodule

// File: rtl/bitalias_bitop.sv
module bitalias_bitop #(
  parameter int DATA_W = 32,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] word_in,
  input  logic [POS_W-1:0]  pos,
  input  logic              nbit,
  output logic [DATA_W-1:0] merged,
  output logic              picked
);
  always_comb begin
    merged      = word_in;
    merged[pos] = nbit;
    picked      = word_in[pos];
  end
endmodule

// File: rtl/bitalias_xlate.sv
module bitalias_xlate #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic              up_write,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [DATA_W-1:0] up_wdata,
  input  logic [BE_W-1:0]   up_be,
  output logic [DATA_W-1:0] up_rdata,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_write,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  output logic [BE_W-1:0]   dn_be,
  output logic              dn_lock,
  input  logic [DATA_W-1:0] dn_rdata,
  input  logic              dn_rvalid
);
  import bitalias_pkg::*;

  xl_state_t        st;
  alias_dec_t       dec;
  logic             op_wr;
  logic [POS_W-1:0] pos_q;
  logic             nbit_q;
  logic [DATA_W-1:0] merged;
  logic             picked;

  bitalias_decode u_dec (
    .addr (up_addr),
    .dec  (dec)
  );

  bitalias_bitop #(.DATA_W(DATA_W)) u_bitop (
    .word_in (dn_rdata),
    .pos     (pos_q),
    .nbit    (nbit_q),
    .merged  (merged),
    .picked  (picked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      up_ready <= 1'b0;
      up_rdata <= '0;
      dn_valid <= 1'b0;
      dn_write <= 1'b0;
      dn_addr  <= '0;
      dn_wdata <= '0;
      dn_be    <= '0;
      dn_lock  <= 1'b0;
      op_wr    <= 1'b0;
      pos_q    <= '0;
      nbit_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (up_valid) begin
            dn_valid <= 1'b1;
            op_wr    <= up_write;
            if (dec.hit) begin
              dn_write <= 1'b0;
              dn_addr  <= dec.word;
              dn_wdata <= '0;
              dn_be    <= '1;
              dn_lock  <= up_write;
              pos_q    <= dec.pos;
              nbit_q   <= up_wdata[0];
              st       <= S_ARD;
            end else begin
              dn_write <= up_write;
              dn_addr  <= up_addr;
              dn_wdata <= up_wdata;
              dn_be    <= up_be;
              st       <= S_PASS;
            end
          end
        end
        S_PASS: begin
          if (dn_ready) begin
            dn_valid <= 1'b0;
            if (op_wr) begin
              up_ready <= 1'b1;
              st       <= S_DONE;
            end else begin
              st <= S_PWAIT;
            end
          end
        end
        S_PWAIT: begin
          if (dn_rvalid) begin
            up_rdata <= dn_rdata;
            up_ready <= 1'b1;
            st       <= S_DONE;
          end
        end
        S_ARD: begin
          if (dn_ready) begin
            dn_valid <= 1'b0;
            st       <= S_AWAIT;
          end
        end
        S_AWAIT: begin
          if (dn_rvalid) begin
            if (op_wr) begin
              dn_valid <= 1'b1;
              dn_write <= 1'b1;
              dn_wdata <= merged;
              st       <= S_AWB;
            end else begin
              up_rdata <= DATA_W'(picked);
              up_ready <= 1'b1;
              st       <= S_DONE;
            end
          end
        end
        S_AWB: begin
          if (dn_ready) begin
            dn_valid <= 1'b0;
            dn_lock  <= 1'b0;
            up_ready <= 1'b1;
            st       <= S_DONE;
          end
        end
        S_DONE: begin
          up_ready <= 1'b0;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bitalias_xlate_chk.sv
module bitalias_xlate_chk (
  input logic        clk,
  input logic        rst,
  input logic        up_ready,
  input logic        up_write,
  input logic [31:0] up_addr,
  input logic [31:0] up_rdata,
  input logic        dn_valid,
  input logic        dn_ready,
  input logic        dn_write,
  input logic [31:0] dn_addr,
  input logic [31:0] dn_wdata,
  input logic [3:0]  dn_be,
  input logic        dn_lock
);
  logic up_in_alias;
  assign up_in_alias = (up_addr[31:25] == 7'h11) || (up_addr[31:25] == 7'h21);

  // R10
  p_reset_quiet_r10: assert property (@(posedge clk)
    rst |=> (!up_ready && !dn_valid && !dn_lock));

  // R8
  p_ready_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    up_ready |=> !up_ready);

  // R8
  p_no_ready_locked_r8: assert property (@(posedge clk) disable iff (rst)
    dn_lock |-> !up_ready);

  // R7
  p_lock_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (dn_lock && !(dn_valid && dn_ready && dn_write)) |=> dn_lock);

  // R1
  p_beat_stable_r1: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=>
      (dn_valid && $stable(dn_addr) && $stable(dn_write) && $stable(dn_wdata) && $stable(dn_be)));

  // R5
  p_locked_full_word_r5: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && dn_lock) |-> (dn_be == 4'hF));

  // R4
  p_alias_bit_only_r4: assert property (@(posedge clk) disable iff (rst)
    (up_ready && !up_write && up_in_alias) |-> (up_rdata[31:1] == 31'd0));
endmodule

bind bitalias_xlate bitalias_xlate_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .up_ready (up_ready),
  .up_write (up_write),
  .up_addr  (up_addr),
  .up_rdata (up_rdata),
  .dn_valid (dn_valid),
  .dn_ready (dn_ready),
  .dn_write (dn_write),
  .dn_addr  (dn_addr),
  .dn_wdata (dn_wdata),
  .dn_be    (dn_be),
  .dn_lock  (dn_lock)
);

// File: tb/bitalias_xlate_bench.sv
`timescale 1ns/1ps
module bitalias_xlate_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        up_valid = 1'b0;
  logic        up_ready;
  logic        up_write = 1'b0;
  logic [31:0] up_addr = '0;
  logic [31:0] up_wdata = '0;
  logic [3:0]  up_be = '0;
  logic [31:0] up_rdata;
  logic        dn_valid;
  logic        dn_ready;
  logic        dn_write;
  logic [31:0] dn_addr;
  logic [31:0] dn_wdata;
  logic [3:0]  dn_be;
  logic        dn_lock;
  logic [31:0] dn_rdata = '0;
  logic        dn_rvalid = 1'b0;

  always #10 clk = ~clk;

  bitalias_xlate u_bitalias_xlate (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // downstream memory model and beat monitor
  logic [31:0] mem [logic [31:0]];
  logic [31:0] refm [logic [31:0]];
  int cyc = 0;
  bit stall_en = 0;
  assign dn_ready = !stall_en || ((cyc % 3) != 1);

  int          nb = 0;
  logic [31:0] b_addr  [4];
  logic [31:0] b_wdata [4];
  logic [3:0]  b_be    [4];
  bit          b_wr    [4];
  bit          b_lock  [4];
  bit          ready_locked = 0;

  function automatic logic [31:0] init_val(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'hA5A5_0F0F;
  endfunction

  function automatic logic [31:0] mrd(input logic [31:0] a);
    logic [31:0] w = {a[31:2], 2'b00};
    return mem.exists(w) ? mem[w] : init_val(w);
  endfunction

  function automatic logic [31:0] rrd(input logic [31:0] a);
    logic [31:0] w = {a[31:2], 2'b00};
    return refm.exists(w) ? refm[w] : init_val(w);
  endfunction

  function automatic logic [31:0] apply_be(input logic [31:0] old, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = d[i*8 +: 8];
    return r;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    dn_rvalid <= 1'b0;
    if (dn_valid && dn_ready) begin
      if (nb < 4) begin
        b_addr[nb] = dn_addr; b_wdata[nb] = dn_wdata; b_be[nb] = dn_be;
        b_wr[nb] = dn_write; b_lock[nb] = dn_lock;
      end
      nb = nb + 1;
      if (dn_write) mem[{dn_addr[31:2], 2'b00}] = apply_be(mrd(dn_addr), dn_wdata, dn_be);
      else begin
        dn_rdata  <= mrd(dn_addr);
        dn_rvalid <= 1'b1;
      end
    end
  end

  always @(negedge clk) if (!rst && up_ready && dn_lock) ready_locked = 1;

  // reference decode written from the address arithmetic
  function automatic bit alias_of(input logic [31:0] a, output logic [31:0] word, output int pos);
    logic [31:0] base, region, off, byteo;
    if (a >= 32'h2200_0000 && a <= 32'h23FF_FFFF) begin base = 32'h2200_0000; region = 32'h2000_0000; end
    else if (a >= 32'h4200_0000 && a <= 32'h43FF_FFFF) begin base = 32'h4200_0000; region = 32'h4000_0000; end
    else begin word = 0; pos = 0; return 0; end
    off   = a - base;
    byteo = off >> 5;
    pos   = int'(byteo % 4) * 8 + int'((off >> 2) & 7);
    word  = region + (byteo & ~32'd3);
    return 1;
  endfunction

  function automatic logic [31:0] alias_addr(input logic [31:0] abase, input logic [31:0] byteo, input int bitn);
    return abase + byteo * 32 + bitn * 4;
  endfunction

  task automatic run(input bit wr, input logic [31:0] a, input logic [31:0] d,
                     input logic [3:0] be, input string tag, output logic [31:0] rd);
    logic [31:0] word, old, expw;
    int pos;
    bit is_al;
    is_al = alias_of(a, word, pos);
    @(negedge clk);
    nb = 0; ready_locked = 0;
    up_valid = 1; up_write = wr; up_addr = a; up_wdata = d; up_be = be;
    do @(negedge clk); while (!up_ready);
    rd = up_rdata;
    @(posedge clk); #1;
    up_valid = 0;
    @(negedge clk);
    chk(!ready_locked, {tag, " R8 ready while locked"}, 32'(ready_locked), 0);
    if (!is_al) begin
      chk(nb == 1 && b_addr[0] == a && b_wr[0] == wr && b_be[0] == be && !b_lock[0] &&
          (!wr || b_wdata[0] == d), {tag, " R1 pass beat"}, b_addr[0], a);
      if (wr) refm[{a[31:2], 2'b00}] = apply_be(rrd(a), d, be);
      else chk(rd == rrd(a), {tag, " R1 pass rdata"}, rd, rrd(a));
    end else if (!wr) begin
      old = rrd(word);
      chk(nb == 1 && b_addr[0] == word && !b_wr[0] && b_be[0] == 4'hF && !b_lock[0],
          {tag, " R4 alias read beat"}, b_addr[0], word);
      chk(rd == 32'(old[pos]), {tag, " R4 alias rdata"}, rd, 32'(old[pos]));
    end else begin
      old = rrd(word);
      expw = old; expw[pos] = d[0];
      chk(nb == 2 && b_addr[0] == word && !b_wr[0] && b_lock[0] && b_lock[1] &&
          b_addr[1] == word && b_wr[1] && b_be[1] == 4'hF,
          {tag, " R5/R7 locked beats"}, b_addr[1], word);
      chk(b_wdata[1] == expw, {tag, " R5 merged word"}, b_wdata[1], expw);
      refm[word] = expw;
    end
    chk(!dn_lock && !dn_valid, {tag, " R7 idle after op"}, 32'(dn_lock), 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R8 actual=%h expected=%h", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, a;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!up_ready && !dn_valid && !dn_lock, "R10 in reset", {dn_lock, dn_valid, up_ready}, 0);
    @(posedge clk); #1 rst = 0;
    @(negedge clk);
    chk(!up_ready && !dn_valid && !dn_lock, "R10 after reset", {dn_lock, dn_valid, up_ready}, 0);

    for (int pass = 0; pass < 2; pass++) begin
      stall_en = (pass == 1);
      // R11 plain region word, then R2 worked example
      run(1, 32'h2000_0300, 32'h0, 4'hF, "R11 plain wr", rd);
      run(1, 32'h2200_6008, 32'h1, 4'h0, "R2 example set", rd);
      run(0, 32'h2000_0300, 0, 4'hF, "R2 plain readback", rd);
      chk(rd == 32'h4, "R2 bit2 of 0x20000300", rd, 32'h4);
      run(0, 32'h2200_6008, 0, 4'hF, "R4 read set bit", rd);
      run(0, 32'h2200_600C, 0, 4'hF, "R4 read clear bit", rd);
      // R3 lane: byte 0x302 bit 5 -> word bit 21
      a = alias_addr(32'h2200_0000, 32'h302, 5);
      run(1, a, 32'h1, 4'h0, "R3 lane set", rd);
      run(0, 32'h2000_0300, 0, 4'hF, "R3 lane readback", rd);
      chk(rd == 32'h0020_0004, "R3 bit21 and bit2", rd, 32'h0020_0004);
      // R6 upper data bits ignored
      run(1, 32'h2200_6008, 32'hFFFF_FFFE, 4'hF, "R6 clear via bit0", rd);
      run(0, 32'h2000_0300, 0, 4'hF, "R6 readback", rd);
      chk(rd == 32'h0020_0000, "R6 only bit2 cleared", rd, 32'h0020_0000);
      // R9 low bits ignored
      run(0, a + 3, 0, 4'hF, "R9 unaligned alias", rd);
      chk(rd == 32'h1, "R9 same bit as aligned", rd, 32'h1);
      run(1, a + 2, 32'h0, 4'hF, "R9 unaligned write", rd);
      // R2 peripheral window
      a = alias_addr(32'h4200_0000, 32'h11, 7);
      run(1, a, 32'h1, 4'h0, "R2 peri set", rd);
      run(0, a, 0, 4'hF, "R2 peri read", rd);
      chk(rd == 32'h1, "R2 peri bit reads one", rd, 32'h1);
      run(1, a, 32'h0, 4'h0, "R2 peri clear", rd);
      // R11 partial write
      run(1, 32'h4000_0008, 32'hDEAD_BEEF, 4'b0010, "R11 byte write", rd);
      run(0, 32'h4000_0008, 0, 4'hF, "R11 byte readback", rd);
      // R1 addresses just outside windows
      run(0, 32'h21FF_FFFC, 0, 4'hF, "R1 below window", rd);
      run(0, 32'h2400_0000, 0, 4'hF, "R1 above window", rd);
      run(1, 32'h4400_0010, 32'h1234_5678, 4'hF, "R1 outside write", rd);
      // R2 top of SRAM window -> word 0x200FFFFC bit 31
      run(1, 32'h23FF_FFFC, 32'h1, 4'h0, "R2 window top", rd);
      run(0, 32'h200F_FFFC, 0, 4'hF, "R2 top readback", rd);
      chk(rd[31] == 1'b1, "R2 top sets bit31", 32'(rd[31]), 1);
    end
    done = 1;
    summary();
    $finish;
  end
endmodule